// File: doc/BRIEF.md
# Timer Frame Register Front End

This block is the 32-bit register side of one memory-mapped timer frame. A free-running 64-bit count arrives from outside. The block shows that count directly and also a virtual count, which is the count minus a programmable 64-bit offset. It also holds a frequency word, a user-access word and two compare channels. The physical channel compares against the raw count and the virtual channel compares against the virtual count.

Each 64-bit quantity appears as a low and a high 32-bit word. The count and timer-value registers are not stored words: they are computed when read. Software programs a channel either with an absolute compare value or with a signed timer value relative to the current count. It then enables and unmasks the channel. The channel's interrupt output stays high for as long as its count is at or above its compare value. The register bus is a simple valid/ready request with a one-cycle registered response.

Top module: `tfr_frame_regs`

## Requirements
- R1: After reset the following are zero: every stored word (frequency, access word, virtual offset, both compare values, both enable and mask bits), `rsp_valid`, `irq_phys` and `irq_virt`. `req_ready` is high.
- R2: Reads at byte offset 0x000 and 0x004 return bits 31:0 and 63:32 of `cnt_i`, sampled in the accepting cycle. Writes to these offsets change nothing.
- R3: Reads at 0x008 and 0x00C return the low and high word of (`cnt_i` minus the virtual offset), modulo 2^64. Writes to these offsets change nothing.
- R4: The frequency word at 0x010 and the access word at 0x014 are plain 32-bit read/write registers.
- R5: The virtual offset is read/write as a low word at 0x018 and a high word at 0x01C. A write to one half leaves the other half unchanged.
- R6: Compare values are read/write at 0x020 (low) and 0x024 (high) for the physical channel, and at 0x030 and 0x034 for the virtual channel. A write to one half leaves the other half unchanged.
- R7: The timer-value words are at 0x028 (physical) and 0x038 (virtual). A read returns (compare minus channel count) truncated to 32 bits. A write sets the compare value to the channel count plus the sign-extended write data.
- R8: The control words are at 0x02C and 0x03C. Bit 0 is enable and bit 1 is mask; both are read/write. Bit 2 reads as enable AND (channel count >= compare) and ignores writes. Bits 31:3 read as zero and ignore writes.
- R9: Each channel's interrupt (`irq_phys`, `irq_virt`) is enable AND NOT mask AND (channel count >= compare), using an unsigned comparison that includes equality. It follows `cnt_i` and register changes in the same cycle. The two channels are independent.
- R10: Offsets at or above 0x040 (any of `req_addr` bits above 5 set) read as zero. Writes to them change no register. Address bits 1:0 are ignored.
- R11: A request is accepted when `req_valid` and `req_ready` are both high. In the next cycle `rsp_valid` is high for exactly one cycle. `rsp_rdata` then carries the read data, or zero for a write. `req_ready` is low while `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 64 | Physical count from the count source |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the frame |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| irq_phys | output | 1 | Physical channel interrupt |
| irq_virt | output | 1 | Virtual channel interrupt |

## Verification
A wrong stored half-word or offset shows up on the very next read response of an affected offset. The virtual count, both timer-value views and the virtual channel interrupt all depend on the offset, so an offset fault appears in several places at once. A compare or control fault appears on the interrupt pin in the cycle after the write edge, with no extra latency, and the read-back of the status bit confirms it. Equality between count and compare is tested in both directions by moving `cnt_i` by one, so an off-by-one comparator shows on the interrupt pin within one cycle.

// File: rtl/tfr_pkg.sv
`timescale 1ns/1ps
package tfr_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 2 * WORD_W;

  // word index = byte offset [5:2]
  localparam logic [3:0] IX_PCNT_LO = 4'h0;
  localparam logic [3:0] IX_PCNT_HI = 4'h1;
  localparam logic [3:0] IX_VCNT_LO = 4'h2;
  localparam logic [3:0] IX_VCNT_HI = 4'h3;
  localparam logic [3:0] IX_FREQ    = 4'h4;
  localparam logic [3:0] IX_ACCESS  = 4'h5;
  localparam logic [3:0] IX_VOFF_LO = 4'h6;
  localparam logic [3:0] IX_VOFF_HI = 4'h7;
  localparam logic [3:0] IX_CH_BASE = 4'h8; // phys at 8, virt at 12
  localparam int         CH_STRIDE  = 4;    // cmp_lo, cmp_hi, tval, ctl

  typedef struct packed {
    logic mask;
    logic en;
  } ctl_t;

  function automatic logic [CNT_W-1:0] virt_count(input logic [CNT_W-1:0] cnt,
                                                  input logic [CNT_W-1:0] off);
    return cnt - off;
  endfunction

  function automatic logic [WORD_W-1:0] tval_view(input logic [CNT_W-1:0] cmp,
                                                  input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] diff;
    diff = cmp - cnt;
    return diff[WORD_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] tval_to_cmp(input logic [CNT_W-1:0]  cnt,
                                                   input logic [WORD_W-1:0] tv);
    return cnt + {{(CNT_W-WORD_W){tv[WORD_W-1]}}, tv};
  endfunction

  function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] cmp);
    return cnt >= cmp;
  endfunction
endpackage

// File: rtl/tfr_common.sv
`timescale 1ns/1ps
module tfr_common
  import tfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_freq,
  input  logic              wr_access,
  input  logic              wr_voff_lo,
  input  logic              wr_voff_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] freq,
  output logic [WORD_W-1:0] access,
  output logic [CNT_W-1:0]  voff
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq   <= '0;
      access <= '0;
      voff   <= '0;
    end else begin
      if (wr_freq)    freq   <= wdata;
      if (wr_access)  access <= wdata;
      if (wr_voff_lo) voff[WORD_W-1:0]     <= wdata;
      if (wr_voff_hi) voff[CNT_W-1:WORD_W] <= wdata;
    end
  end
endmodule

// File: rtl/tfr_channel.sv
`timescale 1ns/1ps
module tfr_channel
  import tfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wr_cmp_lo,
  input  logic              wr_cmp_hi,
  input  logic              wr_tval,
  input  logic              wr_ctl,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp,
  output logic [WORD_W-1:0] tval,
  output logic [WORD_W-1:0] ctl_word,
  output logic              hit,
  output logic              irq
);
  ctl_t ctl;
  logic status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
      ctl <= '0;
    end else begin
      if (wr_cmp_lo) cmp[WORD_W-1:0]     <= wdata;
      if (wr_cmp_hi) cmp[CNT_W-1:WORD_W] <= wdata;
      if (wr_tval)   cmp <= tval_to_cmp(cnt, wdata);
      if (wr_ctl) begin
        ctl.en   <= wdata[0];
        ctl.mask <= wdata[1];
      end
    end
  end

  assign hit      = reached(cnt, cmp);
  assign status   = ctl.en & hit;
  assign irq      = status & ~ctl.mask;
  assign tval     = tval_view(cmp, cnt);
  assign ctl_word = {{(WORD_W-3){1'b0}}, status, ctl.mask, ctl.en};
endmodule

// File: rtl/tfr_frame_regs.sv
`timescale 1ns/1ps
module tfr_frame_regs
  import tfr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              irq_phys,
  output logic              irq_virt
);
  localparam int NUM_WORDS = 16;
  localparam int NUM_CH    = 2;

  logic                        accept;
  logic                        mapped;
  logic [3:0]                  widx;
  logic [NUM_WORDS-1:0]        wr_sel;
  logic [WORD_W-1:0]           freq, access;
  logic [CNT_W-1:0]            voff;
  logic [CNT_W-1:0]            vcnt_w;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt, ch_cmp;
  logic [NUM_CH-1:0][WORD_W-1:0] ch_tval, ch_ctl;
  logic [NUM_CH-1:0]           ch_hit, ch_irq;
  logic [CNT_W-1:0]            p_cmp_w, v_cmp_w;
  logic [WORD_W-1:0]           rd_mux;

  assign req_ready = ~rsp_valid;
  assign accept    = req_valid & req_ready;
  assign widx      = req_addr[5:2];
  assign mapped    = (req_addr[ADDR_W-1:6] == '0);
  assign vcnt_w    = virt_count(cnt_i, voff);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wsel
    assign wr_sel[w] = accept & req_write & mapped & (widx == 4'(w));
  end

  tfr_common u_common (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_freq    (wr_sel[IX_FREQ]),
    .wr_access  (wr_sel[IX_ACCESS]),
    .wr_voff_lo (wr_sel[IX_VOFF_LO]),
    .wr_voff_hi (wr_sel[IX_VOFF_HI]),
    .wdata      (req_wdata),
    .freq       (freq),
    .access     (access),
    .voff       (voff)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int B = int'(IX_CH_BASE) + c * CH_STRIDE;
    if (c == 0) begin : g_src_phys
      assign ch_cnt[c] = cnt_i;
    end else begin : g_src_virt
      assign ch_cnt[c] = vcnt_w;
    end
    tfr_channel u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (ch_cnt[c]),
      .wr_cmp_lo (wr_sel[B]),
      .wr_cmp_hi (wr_sel[B+1]),
      .wr_tval   (wr_sel[B+2]),
      .wr_ctl    (wr_sel[B+3]),
      .wdata     (req_wdata),
      .cmp       (ch_cmp[c]),
      .tval      (ch_tval[c]),
      .ctl_word  (ch_ctl[c]),
      .hit       (ch_hit[c]),
      .irq       (ch_irq[c])
    );
  end

  assign irq_phys = ch_irq[0];
  assign irq_virt = ch_irq[1];
  assign p_cmp_w  = ch_cmp[0];
  assign v_cmp_w  = ch_cmp[1];

  always_comb begin
    rd_mux = '0;
    case (widx)
      IX_PCNT_LO: rd_mux = cnt_i[WORD_W-1:0];
      IX_PCNT_HI: rd_mux = cnt_i[CNT_W-1:WORD_W];
      IX_VCNT_LO: rd_mux = vcnt_w[WORD_W-1:0];
      IX_VCNT_HI: rd_mux = vcnt_w[CNT_W-1:WORD_W];
      IX_FREQ:    rd_mux = freq;
      IX_ACCESS:  rd_mux = access;
      IX_VOFF_LO: rd_mux = voff[WORD_W-1:0];
      IX_VOFF_HI: rd_mux = voff[CNT_W-1:WORD_W];
      4'h8:       rd_mux = ch_cmp[0][WORD_W-1:0];
      4'h9:       rd_mux = ch_cmp[0][CNT_W-1:WORD_W];
      4'hA:       rd_mux = ch_tval[0];
      4'hB:       rd_mux = ch_ctl[0];
      4'hC:       rd_mux = ch_cmp[1][WORD_W-1:0];
      4'hD:       rd_mux = ch_cmp[1][CNT_W-1:WORD_W];
      4'hE:       rd_mux = ch_tval[1];
      default:    rd_mux = ch_ctl[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) rsp_rdata <= (req_write || !mapped) ? '0 : rd_mux;
    end
  end
endmodule

// File: rtl/tfr_frame_regs_chk.sv
`timescale 1ns/1ps
module tfr_frame_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [63:0]       cnt_i,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              irq_phys,
  input logic              irq_virt,
  input logic [63:0]       p_cmp,
  input logic [63:0]       v_cmp,
  input logic [63:0]       v_cnt
);
  logic rd_acc, wr_acc;
  assign rd_acc = req_valid && req_ready && !req_write;
  assign wr_acc = req_valid && req_ready && req_write;

  a_r11_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r11_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  a_r11_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r2_count_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && req_addr == '0) |=> rsp_rdata == $past(cnt_i[31:0]));
  a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && req_addr[ADDR_W-1:6] != '0) |=> rsp_rdata == 32'h0);
  a_r11_write_resp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> rsp_rdata == 32'h0);
  a_r6_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == ADDR_W'('h20)) |=> p_cmp[63:32] == $past(p_cmp[63:32]));
  a_r6_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == ADDR_W'('h34)) |=> v_cmp[31:0] == $past(v_cmp[31:0]));
  a_r9_phys_reach: assert property (@(posedge clk) disable iff (!rst_n)
    irq_phys |-> cnt_i >= p_cmp);
  a_r9_virt_reach: assert property (@(posedge clk) disable iff (!rst_n)
    irq_virt |-> v_cnt >= v_cmp);
endmodule

bind tfr_frame_regs tfr_frame_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_i     (cnt_i),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .irq_phys  (irq_phys),
  .irq_virt  (irq_virt),
  .p_cmp     (p_cmp_w),
  .v_cmp     (v_cmp_w),
  .v_cnt     (vcnt_w)
);

// File: tb/test_tfr_frame_regs.sv
`timescale 1ns/1ps
module test_tfr_frame_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq_phys, irq_virt;
  logic [31:0] rsp_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
    logic [11:0] addr;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  tfr_frame_regs #(.ADDR_W(12)) i_tfr_frame_regs (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_phys(irq_phys), .irq_virt(irq_virt)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each response with the queued expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_checks++;
      if (sb.size() == 0) begin
        n_fails++;
        $display("FAIL R11: unexpected response actual %h expected none", rsp_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (rsp_rdata !== it.exp) begin
          n_fails++;
          $display("FAIL %s @%h: actual %h expected %h", it.tag, it.addr, rsp_rdata, it.exp);
        end
      end
    end
  end

  task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    sb.push_back('{exp: (wr ? 32'h0 : exp), tag: tag, addr: a});
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus(1'b1, a, d, 32'h0, "R11");
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus(1'b0, a, 32'h0, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] voff, pcmp, vcmp, vc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(rsp_valid, 0, "R1"); chk(irq_phys, 0, "R1"); chk(irq_virt, 0, "R1");
    chk(req_ready, 1, "R1");
    rd(12'h010, 32'h0, "R1"); rd(12'h018, 32'h0, "R1");
    rd(12'h020, 32'h0, "R1"); rd(12'h02C, 32'h0, "R1");
    // R11 ready drops while the response is out
    chk(rsp_valid, 1, "R11"); chk(req_ready, 0, "R11");

    // R2 physical count view, writes ignored
    cnt = 64'h0000_0012_3456_789A;
    rd(12'h000, cnt[31:0], "R2"); rd(12'h004, cnt[63:32], "R2");
    wr(12'h000, 32'hFFFF_FFFF); wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h000, cnt[31:0], "R2"); rd(12'h004, cnt[63:32], "R2");
    rd(12'h002, cnt[31:0], "R10");

    // R5 virtual offset halves
    wr(12'h018, 32'h0000_0100); wr(12'h01C, 32'h0000_0001);
    voff = 64'h1_0000_0100;
    rd(12'h018, voff[31:0], "R5"); rd(12'h01C, voff[63:32], "R5");
    wr(12'h018, 32'h0000_0200); voff = 64'h1_0000_0200;
    rd(12'h01C, 32'h1, "R5"); rd(12'h018, 32'h200, "R5");

    // R3 virtual count view
    vc = cnt - voff;
    rd(12'h008, vc[31:0], "R3"); rd(12'h00C, vc[63:32], "R3");
    wr(12'h008, 32'h0); wr(12'h00C, 32'h0);
    rd(12'h008, vc[31:0], "R3"); rd(12'h00C, vc[63:32], "R3");

    // R4 frequency and access words
    wr(12'h010, 32'h05F5_E100); wr(12'h014, 32'h0000_00A5);
    rd(12'h010, 32'h05F5_E100, "R4"); rd(12'h014, 32'h0000_00A5, "R4");

    // R6 compare halves
    wr(12'h020, 32'h3456_7000);
    rd(12'h020, 32'h3456_7000, "R6"); rd(12'h024, 32'h0, "R6");
    wr(12'h024, 32'h0000_0012);
    rd(12'h020, 32'h3456_7000, "R6"); rd(12'h024, 32'h12, "R6");
    pcmp = 64'h12_3456_7000;
    // R7 timer value read (negative distance)
    vc = pcmp - cnt;
    rd(12'h028, vc[31:0], "R7");

    // R8 / R9 control and interrupt
    wr(12'h02C, 32'h1);
    @(negedge clk); chk(irq_phys, 1, "R9");
    rd(12'h02C, 32'h5, "R8");
    wr(12'h02C, 32'h3);
    @(negedge clk); chk(irq_phys, 0, "R9 masked");
    rd(12'h02C, 32'h7, "R8");
    wr(12'h02C, 32'hFFFF_FFFC);
    @(negedge clk); chk(irq_phys, 0, "R9 disabled");
    rd(12'h02C, 32'h0, "R8");
    wr(12'h02C, 32'hFFFF_FFF9);
    @(negedge clk); chk(irq_phys, 1, "R9");
    rd(12'h02C, 32'h5, "R8 upper ignored");

    // R7 timer value writes
    wr(12'h028, 32'h0000_0100); pcmp = cnt + 64'h100;
    rd(12'h020, pcmp[31:0], "R7"); rd(12'h024, pcmp[63:32], "R7");
    chk(irq_phys, 0, "R9 future");
    rd(12'h02C, 32'h1, "R8 status clear");
    rd(12'h028, 32'h0000_0100, "R7");
    wr(12'h028, 32'hFFFF_FFF0); pcmp = cnt - 64'd16;
    rd(12'h020, pcmp[31:0], "R7"); rd(12'h024, pcmp[63:32], "R7");
    chk(irq_phys, 1, "R9 past");
    // R9 equality boundary
    wr(12'h028, 32'h0);
    @(negedge clk); chk(irq_phys, 1, "R9 equal");
    cnt = cnt - 64'd1;
    #1 chk(irq_phys, 0, "R9 one below");

    // virtual channel
    vc = cnt - voff;
    vcmp = vc + 64'h66;
    wr(12'h034, vcmp[63:32]); wr(12'h030, vcmp[31:0]);
    rd(12'h030, vcmp[31:0], "R6"); rd(12'h034, vcmp[63:32], "R6");
    wr(12'h03C, 32'h1);
    @(negedge clk); chk(irq_virt, 0, "R9 virt below");
    rd(12'h03C, 32'h1, "R8");
    rd(12'h038, 32'h66, "R7 virt");
    wr(12'h018, 32'h0000_0100); voff = 64'h1_0000_0100;
    @(negedge clk); chk(irq_virt, 1, "R9 virt via offset");
    chk(irq_phys, 0, "R9 channels independent");
    rd(12'h03C, 32'h5, "R8");
    vc = cnt - voff;
    rd(12'h008, vc[31:0], "R3");

    // R10 unmapped offsets
    wr(12'h040, 32'hDEAD_BEEF); wr(12'h050, 32'h1234_5678);
    rd(12'h040, 32'h0, "R10"); rd(12'hFFC, 32'h0, "R10");
    rd(12'h010, 32'h05F5_E100, "R10 no alias");
    rd(12'h014, 32'h0000_00A5, "R10 no alias");

    repeat (4) @(negedge clk);
    chk(sb.size(), 0, "R11 all responses");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule